// File: doc/BRIEF.md
# Programmable Peripheral Chip-Select Decoder

This block turns the address of each bus cycle into one of six active-low peripheral select lines. Software programs a 2 KB-aligned base address. Above that base lie eight 256-byte slots. Slots 0 to 3 drive the four low selects. Slots 5 and 6 drive the two high selects. Slots 4 and 7 drive nothing. Every cycle is compared against either memory space or I/O space, and software chooses which one.

Two write-only configuration words control the block. The base word holds the base address and the wait count for the low group. The auxiliary word holds these settings:
- the wait count for the high group;
- a ready-mode bit for each group;
- the space select;
- a pin-mode bit, which turns the two high lines into outputs for the latched address bits A1 and A2.

No select can assert until both words have been written at least once after reset.

The block produces a cycle-ready indication for the bus controller. On the start of each cycle, a wait counter loads the wait count of the selected group. Ready stays low until that counter reaches zero. If the group's ready-mode bit is clear, ready also waits for the external ready input.

Top module: `pcs_decoder`

## Requirements
- R1: After reset, all six select outputs are high and `cyc_ready` is low. This stays true after only one of the two configuration words has been written. Selects can assert only once both words have been written.
- R2: A cycle hits the select window only when `bus_addr[19:11]` equals the base field, which is written through `cfg_wdata[15:7]` with `cfg_sel`=0.
- R3: Inside the window, `bus_addr[10:8]` picks the slot:
  - slots 0 to 3 assert `sel_lo_n[0..3]`;
  - slot 5 asserts `sel_hi_n[0]`;
  - slot 6 asserts `sel_hi_n[1]`;
  - slots 4 and 7 assert nothing.
- R4: Auxiliary bit 4 (`cfg_sel`=1) sets the space: 1 means I/O, 0 means memory. A select asserts only when `bus_io` equals this bit.
- R5: A select goes low on the clock edge that samples `cyc_start`. It stays low until the edge that samples `cyc_end`, and goes high on that edge.
- R6: For a low select, with wait count W taken from base-word bits 3:0 (range 0 to 15), `cyc_ready` is low for exactly W cycles after the start edge and then rises (subject to R8).
- R7: For a high select, W comes from auxiliary bits 1:0 (range 0 to 3), with the same timing as R6.
- R8: The ready-mode bits are auxiliary bit 3 for the low group and auxiliary bit 2 for the high group.
  - When the group's bit is 1, `ext_rdy` is ignored.
  - When the bit is 0, `cyc_ready` rises only after the count has expired and `ext_rdy` is high.
- R9: When auxiliary bit 5 is 1 and both words have been written:
  - `sel_hi_n[0]` drives A1 and `sel_hi_n[1]` drives A2, using the values latched at the last `cyc_start`;
  - these values hold between cycle starts;
  - slots 5 and 6 assert no select.
- R10: `cyc_ready` stays low throughout a cycle that hits no select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Target of the write: 0 = base word, 1 = auxiliary word |
| cfg_wdata | input | 16 | Configuration write data |
| cyc_start | input | 1 | One-cycle pulse at the start of a bus cycle; address and type are valid with it |
| cyc_end | input | 1 | One-cycle pulse that ends the bus cycle |
| bus_addr | input | 20 | Bus address (I/O addresses use only the low 16 bits) |
| bus_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| ext_rdy | input | 1 | External ready, already synchronised |
| sel_lo_n | output | 4 | Active-low selects for slots 0 to 3 |
| sel_hi_n | output | 2 | Active-low selects for slots 5 and 6, or latched A1/A2 |
| cyc_ready | output | 1 | Cycle may complete |

## Verification
The bench first runs directed cycles:
- every one of the eight slots, which separates the six active slots from the two reserved ones;
- a wrong base and a wrong space, which show that the window compare is exact;
- the extreme wait counts 0, 3 and 15, which expose off-by-one timing on the ready edge.

Cycles with `ext_rdy` held low, run in both ready modes, distinguish counting only from counting plus the external handshake. The address-pin mode is exercised with addresses whose bits 2:1 vary.

Seeded random cycles then re-program both words and place addresses mostly inside the window. This mixes groups, spaces and wait counts, with each result predicted by a bench model.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int ADDR_W     = 20;
    localparam int REG_W      = 16;
    localparam int BASE_LSB   = 11;
    localparam int BASE_W     = ADDR_W - BASE_LSB;
    localparam int SLOT_LSB   = 8;
    localparam int SLOT_W     = BASE_LSB - SLOT_LSB;
    localparam int LO_N       = 4;
    localparam int HI_N       = 2;
    localparam int HI_SLOT0   = 5;
    localparam int LO_WAIT_W  = 4;
    localparam int HI_WAIT_W  = 2;
    localparam int BASE_FLD_L = REG_W - BASE_W;

    // auxiliary word bit positions
    localparam int AUX_IGN_HI = 2;
    localparam int AUX_IGN_LO = 3;
    localparam int AUX_IO     = 4;
    localparam int AUX_AMODE  = 5;

    typedef enum logic {REG_BASE = 1'b0, REG_AUX = 1'b1} pcs_reg_e;

    typedef struct packed {
        logic [BASE_W-1:0]    base;
        logic [LO_WAIT_W-1:0] wait_lo;
        logic [HI_WAIT_W-1:0] wait_hi;
        logic                 ign_lo;
        logic                 ign_hi;
        logic                 io_space;
        logic                 addr_mode;
        logic                 enabled;
    } pcs_cfg_t;

    typedef struct packed {
        logic [LO_N-1:0] lo;
        logic [HI_N-1:0] hi;
    } pcs_hit_t;

    function automatic logic [LO_WAIT_W-1:0] pick_wait(pcs_hit_t h, pcs_cfg_t c);
        if (|h.lo)      return c.wait_lo;
        else if (|h.hi) return {{(LO_WAIT_W-HI_WAIT_W){1'b0}}, c.wait_hi};
        else            return '0;
    endfunction

    function automatic logic pick_ign(pcs_hit_t h, pcs_cfg_t c);
        return (|h.lo) ? c.ign_lo : c.ign_hi;
    endfunction
endpackage

// File: rtl/pcs_cfg_regs.sv
module pcs_cfg_regs
    import pcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             sel,
    input  logic [REG_W-1:0] wdata,
    output pcs_cfg_t         cfg
);
    logic [BASE_W-1:0]    base_q;
    logic [LO_WAIT_W-1:0] wlo_q;
    logic [HI_WAIT_W-1:0] whi_q;
    logic ign_lo_q, ign_hi_q, io_q, amode_q;
    logic seen_base_q, seen_aux_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q      <= '0;
            wlo_q       <= '0;
            whi_q       <= '0;
            ign_lo_q    <= 1'b0;
            ign_hi_q    <= 1'b0;
            io_q        <= 1'b0;
            amode_q     <= 1'b0;
            seen_base_q <= 1'b0;
            seen_aux_q  <= 1'b0;
        end else if (we) begin
            if (pcs_reg_e'(sel) == REG_BASE) begin
                base_q      <= wdata[REG_W-1:BASE_FLD_L];
                wlo_q       <= wdata[LO_WAIT_W-1:0];
                seen_base_q <= 1'b1;
            end else begin
                whi_q      <= wdata[HI_WAIT_W-1:0];
                ign_hi_q   <= wdata[AUX_IGN_HI];
                ign_lo_q   <= wdata[AUX_IGN_LO];
                io_q       <= wdata[AUX_IO];
                amode_q    <= wdata[AUX_AMODE];
                seen_aux_q <= 1'b1;
            end
        end
    end

    always_comb begin
        cfg.base      = base_q;
        cfg.wait_lo   = wlo_q;
        cfg.wait_hi   = whi_q;
        cfg.ign_lo    = ign_lo_q;
        cfg.ign_hi    = ign_hi_q;
        cfg.io_space  = io_q;
        cfg.addr_mode = amode_q;
        cfg.enabled   = seen_base_q & seen_aux_q;
    end

    // R1: once both words are written the block stays enabled until reset
    assert_enable_sticky_R1: assert property (@(posedge clk) disable iff (rst)
        cfg.enabled |=> cfg.enabled);
endmodule

// File: rtl/pcs_addr_match.sv
module pcs_addr_match
    import pcs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              io,
    input  pcs_cfg_t          cfg,
    output pcs_hit_t          hit
);
    logic              in_window;
    logic [SLOT_W-1:0] slot;

    always_comb begin
        slot      = addr[BASE_LSB-1:SLOT_LSB];
        in_window = cfg.enabled && (io == cfg.io_space)
                    && (addr[ADDR_W-1:BASE_LSB] == cfg.base);
    end

    for (genvar i = 0; i < LO_N; i++) begin : g_lo
        assign hit.lo[i] = in_window && (slot == SLOT_W'(i));
    end

    for (genvar j = 0; j < HI_N; j++) begin : g_hi
        assign hit.hi[j] = in_window && !cfg.addr_mode
                           && (slot == SLOT_W'(HI_SLOT0 + j));
    end
endmodule

// File: rtl/pcs_wait_timer.sv
module pcs_wait_timer
    import pcs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 stop,
    input  logic                 hit_any,
    input  logic [LO_WAIT_W-1:0] load_val,
    input  logic                 ign,
    input  logic                 ext_rdy,
    output logic                 ready
);
    logic [LO_WAIT_W-1:0] cnt_q;
    logic busy_q, ign_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            ign_q  <= 1'b0;
        end else if (start) begin
            busy_q <= hit_any;
            cnt_q  <= hit_any ? load_val : '0;
            ign_q  <= ign;
        end else if (stop) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign ready = busy_q && (cnt_q == '0) && (ign_q || ext_rdy);

    // R8: in handshake mode ready never rises without the external input
    assert_need_ext_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !ign_q && !ext_rdy) |-> !ready);
    // R10: ready stays low with no select active
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !ready);
    // R6: a nonzero load keeps ready low in the following cycle
    assert_wait_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (start && hit_any && load_val != '0) |=> !ready);
endmodule

// File: rtl/pcs_decoder.sv
module pcs_decoder
    import pcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              cyc_start,
    input  logic              cyc_end,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_io,
    input  logic              ext_rdy,
    output logic [LO_N-1:0]   sel_lo_n,
    output logic [HI_N-1:0]   sel_hi_n,
    output logic              cyc_ready
);
    pcs_cfg_t cfg;
    pcs_hit_t hit;
    logic [LO_N-1:0] lo_q;
    logic [HI_N-1:0] hi_q;
    logic [HI_N-1:0] alat_q;

    pcs_cfg_regs u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .cfg(cfg)
    );

    pcs_addr_match u_match (
        .addr(bus_addr), .io(bus_io), .cfg(cfg), .hit(hit)
    );

    pcs_wait_timer u_timer (
        .clk(clk), .rst(rst), .start(cyc_start), .stop(cyc_end),
        .hit_any(|{hit.lo, hit.hi}), .load_val(pick_wait(hit, cfg)),
        .ign(pick_ign(hit, cfg)), .ext_rdy(ext_rdy), .ready(cyc_ready)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= '0;
            hi_q   <= '0;
            alat_q <= '1;
        end else if (cyc_start) begin
            lo_q <= hit.lo;
            hi_q <= hit.hi;
            if (cfg.addr_mode) alat_q <= bus_addr[HI_N:1];
        end else if (cyc_end) begin
            lo_q <= '0;
            hi_q <= '0;
        end
    end

    assign sel_lo_n = ~lo_q;
    assign sel_hi_n = (cfg.enabled && cfg.addr_mode) ? alat_q : ~hi_q;

    // R3: at most one select active at once
    assert_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lo_q, hi_q}));
    // R1: nothing asserts before both words are written
    assert_quiet_until_cfg_R1: assert property (@(posedge clk) disable iff (rst)
        !cfg.enabled |-> (&sel_lo_n && &sel_hi_n && !cyc_ready));
    // R5: an end without a new start releases the low selects
    assert_end_release_R5: assert property (@(posedge clk) disable iff (rst)
        (cyc_end && !cyc_start) |=> &sel_lo_n);
    // R9: address pins hold between cycle starts
    assert_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg.enabled && cfg.addr_mode && !cyc_start && !cfg_we) |=> $stable(sel_hi_n));
endmodule

// File: tb/tb_pcs_decoder.sv
module tb_pcs_decoder;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic cyc_start = 1'b0, cyc_end = 1'b0, bus_io = 1'b0, ext_rdy = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [3:0] sel_lo_n;
    logic [1:0] sel_hi_n;
    logic cyc_ready;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench model of the configuration
    logic [8:0] m_base = '0;
    logic [3:0] m_wlo = '0;
    logic [1:0] m_whi = '0;
    bit m_ignlo = 0, m_ignhi = 0, m_io = 0, m_am = 0, m_sb = 0, m_sa = 0;

    always #2 clk = ~clk;

    pcs_decoder dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cyc_start(cyc_start), .cyc_end(cyc_end),
        .bus_addr(bus_addr), .bus_io(bus_io), .ext_rdy(ext_rdy),
        .sel_lo_n(sel_lo_n), .sel_hi_n(sel_hi_n), .cyc_ready(cyc_ready)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input bit aux, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = aux; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (!aux) begin
            m_base = d[15:7]; m_wlo = d[3:0]; m_sb = 1;
        end else begin
            m_whi = d[1:0]; m_ignhi = d[2]; m_ignlo = d[3];
            m_io = d[4]; m_am = d[5]; m_sa = 1;
        end
    endtask

    function automatic logic [3:0] exp_lo(logic [19:0] a, bit io);
        bit win = m_sb && m_sa && (io == m_io) && (a[19:11] == m_base);
        return (win && a[10:8] < 3'd4) ? (4'b0001 << a[10:8]) : 4'b0000;
    endfunction

    function automatic logic [1:0] exp_hi(logic [19:0] a, bit io);
        bit win = m_sb && m_sa && (io == m_io) && (a[19:11] == m_base) && !m_am;
        if (win && a[10:8] == 3'd5) return 2'b01;
        if (win && a[10:8] == 3'd6) return 2'b10;
        return 2'b00;
    endfunction

    task automatic bus_cycle(input logic [19:0] a, input bit io, input bit ext, input string tag);
        logic [3:0] elo = exp_lo(a, io);
        logic [1:0] ehi = exp_hi(a, io);
        bit en = m_sb && m_sa;
        bit act = (elo != 0) || (ehi != 0);
        int w = (elo != 0) ? int'(m_wlo) : int'(m_whi);
        bit ign = (elo != 0) ? m_ignlo : m_ignhi;
        logic [1:0] ehin = (en && m_am) ? a[2:1] : ~ehi;
        @(negedge clk);
        cyc_start = 1'b1; bus_addr = a; bus_io = io; ext_rdy = ext;
        @(negedge clk);
        cyc_start = 1'b0;
        chk({4'b0, sel_lo_n}, {4'b0, ~elo}, {tag, " R3 R5 low selects"});
        chk({6'b0, sel_hi_n}, {6'b0, ehin}, {tag, " R3 R9 high pins"});
        for (int j = 0; j <= w + 1; j++) begin
            if (j > 0) @(negedge clk);
            chk({7'b0, cyc_ready}, {7'b0, act && (j >= w) && (ign || ext)},
                act ? {tag, " R6 R7 R8 ready"} : {tag, " R10 ready idle"});
            chk({4'b0, sel_lo_n}, {4'b0, ~elo}, {tag, " R5 hold"});
        end
        cyc_end = 1'b1;
        @(negedge clk);
        cyc_end = 1'b0;
        chk({4'b0, sel_lo_n}, 8'h0f, {tag, " R5 release low"});
        chk({6'b0, sel_hi_n}, {6'b0, (en && m_am) ? a[2:1] : 2'b11}, {tag, " R5 R9 release high"});
        chk({7'b0, cyc_ready}, 8'h00, {tag, " R5 ready drop"});
    endtask

    function automatic logic [19:0] in_win(logic [2:0] slot, logic [7:0] off);
        return {m_base, slot, off};
    endfunction

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({4'b0, sel_lo_n}, 8'h0f, "R1 reset low selects");
        chk({6'b0, sel_hi_n}, 8'h03, "R1 reset high selects");
        chk({7'b0, cyc_ready}, 8'h00, "R1 reset ready");

        // base only: still quiet (R1)
        wr(0, {9'h0a5, 3'b111, 4'd2});
        bus_cycle({9'h0a5, 3'd0, 8'h10}, 0, 1, "R1 base-only");
        // both written: memory space, ignore ext on both groups
        wr(1, 16'h000c | 16'h0001);
        for (int s = 0; s < 8; s++) bus_cycle(in_win(3'(s), 8'h44), 0, 1, "R3 slot sweep");
        bus_cycle({9'h0a4, 3'd1, 8'h00}, 0, 1, "R2 wrong base");
        bus_cycle({9'h0a5, 3'd1, 8'h00}, 1, 1, "R4 wrong space");
        // wait extremes
        wr(0, {9'h0a5, 3'b111, 4'd0});
        bus_cycle(in_win(3'd2, 8'h00), 0, 0, "R6 wait zero");
        wr(0, {9'h0a5, 3'b111, 4'd15});
        bus_cycle(in_win(3'd3, 8'hff), 0, 0, "R6 wait fifteen");
        wr(1, 16'h000f);
        bus_cycle(in_win(3'd6, 8'h01), 0, 0, "R7 wait three");
        // handshake mode, ext low then high (R8)
        wr(1, 16'h0011);
        wr(0, {9'h00a, 3'b111, 4'd1});
        bus_cycle(in_win(3'd0, 8'h00), 1, 0, "R8 ext low lo");
        bus_cycle(in_win(3'd5, 8'h00), 1, 0, "R8 ext low hi");
        bus_cycle(in_win(3'd1, 8'h00), 1, 1, "R8 ext high");
        // address pin mode (R9)
        wr(1, 16'h0024);
        bus_cycle(in_win(3'd5, 8'h02), 0, 1, "R9 addr mode a");
        bus_cycle(in_win(3'd6, 8'h04), 0, 1, "R9 addr mode b");
        bus_cycle(in_win(3'd0, 8'h06), 0, 1, "R9 addr mode c");

        // seeded random mix
        for (int k = 0; k < 300; k++) begin
            if ($urandom_range(0, 9) == 0) wr(0, 16'($urandom));
            if ($urandom_range(0, 9) == 0) wr(1, 16'($urandom) & 16'h003f);
            if ($urandom_range(0, 3) != 0)
                bus_cycle(in_win(3'($urandom), 8'($urandom)), m_io ^ ($urandom_range(0, 7) == 0),
                          1'($urandom), "random in-window");
            else
                bus_cycle(20'($urandom), 1'($urandom), 1'($urandom), "random any");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule